// File: doc/BRIEF.md
# Pair-wise Temporal Correlation Prefetcher

This block watches the stream of cache-miss line addresses and learns, for each address, which addresses have tended to miss right after it. When an address misses again, the block issues prefetch requests for the successors it trusts. Because it learns from address history and not from arithmetic between addresses, it can follow pointer-linked structures that have no stride.

History lives in a direct-mapped table. The table is indexed by a hash of the miss address, and each entry keeps a full-address tag. Every entry has a fixed number of successor slots (the breadth), and each slot carries a 2-bit confidence count. After the first lookup, the block can chain further lookups, using the strongest trusted successor as the next key, to see several misses ahead (the depth). Each lookup level produces one cycle of prefetch output. That output holds a valid bit and an address for every slot.

Top module: `corr_prefetcher`

## Requirements
- R1: After reset every table entry is empty, `pfValid` is zero, and no previous miss is remembered. The first miss after reset therefore trains nothing and produces no prefetch.
- R2: Each miss trains the pair (previous miss, this miss). A successor seen once for a key gets confidence 1 and is not prefetched. A second sighting raises it to 2, and after that a miss on the key prefetches it.
- R3: A miss sampled on rising edge N is trained at edge N+1. Its first prefetch level is registered at edge N+2 and is visible for exactly one cycle. Misses must be at least 6 cycles apart and only arrive while the block is idle.
- R4: Prefetch output slot s uses `pfValid[s]` and `pfAddr[s*ADDR_W +: ADDR_W]`. An entry keeps up to BREADTH distinct successors, and every successor in it with confidence 2 or more is prefetched in the same cycle.
- R5: A successor that is seen again increments its count, saturating at 3. Every other live successor in that entry decrements by one, and a count that reaches 0 frees its slot.
- R6: A successor that is not yet recorded for a key takes the slot with the lowest count (the lowest slot index on a tie) and starts at count 1. The other slots keep their counts.
- R7: The table index is the low IDX_W address bits XOR the next IDX_W bits. A lookup whose stored tag differs from the key gives no prefetch.
- R8: If a level has a trusted successor, the next level looks up the one with the highest count (the lowest slot on a tie) on the following cycle. There are at most DEPTH levels per miss.
- R9: The chain ends at the first level that holds no successor with count 2 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Marks a miss address in this cycle |
| missAddr | input | ADDR_W | Miss line address |
| pfValid | output | BREADTH | Per-slot prefetch request valid |
| pfAddr | output | BREADTH*ADDR_W | Per-slot prefetch line address |

## Verification
The assertions assume that a miss is only presented while the block is idle, since it has no way to push back on a miss that arrives during training or a chained lookup. The bench meets this by leaving six cycles after each miss before presenting the next one. That gap covers capture, training and both lookup levels at the default depth. Each scenario starts from reset and uses addresses whose hashed indices it picks on purpose, either distinct or deliberately aliased.

// File: rtl/cp_pkg.sv
package cp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRAIN = 2'd1,
    ST_LOOK  = 2'd2
  } cp_state_e;

  typedef struct packed {
    logic capture;
    logic train;
    logic look;
    logic advance;
  } cp_strobe_t;

endpackage

// File: rtl/cp_control.sv
module cp_control
  import cp_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       missValid,
  input  logic       chainOk,
  output cp_strobe_t strobe
);

  localparam int LVL_W = $clog2(DEPTH) + 1;

  cp_state_e  state;
  logic [LVL_W-1:0] level;

  always_comb begin
    strobe.capture = (state == ST_IDLE) && missValid;
    strobe.train   = (state == ST_TRAIN);
    strobe.look    = (state == ST_LOOK);
    strobe.advance = (state == ST_LOOK) && chainOk && (int'(level) < DEPTH - 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      level <= '0;
    end else begin
      unique case (state)
        ST_IDLE:  if (missValid) state <= ST_TRAIN;
        ST_TRAIN: begin
          state <= ST_LOOK;
          level <= '0;
        end
        ST_LOOK: begin
          if (strobe.advance) level <= level + 1'b1;
          else state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_MISS_IN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    missValid |-> state == ST_IDLE); // R3

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(level) < DEPTH); // R8

  AST_CHAIN_CONFIDENT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOOK && $past(state) == ST_LOOK && $past(rstN)) |-> $past(chainOk)); // R9

endmodule

// File: rtl/cp_datapath.sv
module cp_datapath
  import cp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 4,
  parameter int BREADTH = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cp_strobe_t                strobe,
  input  logic [ADDR_W-1:0]         missAddr,
  output logic                      chainOk,
  output logic [BREADTH-1:0]        pfValid,
  output logic [BREADTH*ADDR_W-1:0] pfAddr
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int SLOT_W  = (BREADTH > 1) ? $clog2(BREADTH) : 1;

  function automatic logic [IDX_W-1:0] hashIdx(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0] ^ a[2*IDX_W-1:IDX_W];
  endfunction

  logic [ADDR_W-1:0] tagArr  [ENTRIES];
  logic              tagVld  [ENTRIES];
  logic [ADDR_W-1:0] succArr [ENTRIES][BREADTH];
  logic [1:0]        confArr [ENTRIES][BREADTH];

  logic [ADDR_W-1:0] curAddr, prevAddr, keyAddr;
  logic              prevVld;

  // training side
  logic [IDX_W-1:0]  tIdx;
  logic              tHit, matchAny;
  logic [SLOT_W-1:0] matchSlot, victim;
  logic [1:0]        victimConf;
  logic [ADDR_W-1:0] nextSucc [BREADTH];
  logic [1:0]        nextConf [BREADTH];

  always_comb begin
    tIdx = hashIdx(prevAddr);
    tHit = tagVld[tIdx] && (tagArr[tIdx] == prevAddr);
    matchAny   = 1'b0;
    matchSlot  = '0;
    victim     = '0;
    victimConf = confArr[tIdx][0];
    for (int s = 0; s < BREADTH; s++) begin
      if (!matchAny && confArr[tIdx][s] != 2'd0 && succArr[tIdx][s] == curAddr) begin
        matchAny  = 1'b1;
        matchSlot = SLOT_W'(s);
      end
      if (confArr[tIdx][s] < victimConf) begin
        victimConf = confArr[tIdx][s];
        victim     = SLOT_W'(s);
      end
    end
    matchAny = matchAny && tHit;
    for (int s = 0; s < BREADTH; s++) begin
      nextSucc[s] = succArr[tIdx][s];
      nextConf[s] = confArr[tIdx][s];
      if (!tHit) begin
        nextConf[s] = (s == 0) ? 2'd1 : 2'd0;
        if (s == 0) nextSucc[s] = curAddr;
      end else if (matchAny) begin
        if (SLOT_W'(s) == matchSlot) begin
          if (confArr[tIdx][s] != 2'd3) nextConf[s] = confArr[tIdx][s] + 2'd1;
        end else if (confArr[tIdx][s] != 2'd0) begin
          nextConf[s] = confArr[tIdx][s] - 2'd1;
        end
      end else if (SLOT_W'(s) == victim) begin
        nextSucc[s] = curAddr;
        nextConf[s] = 2'd1;
      end
    end
  end

  // lookup side
  logic [IDX_W-1:0]          lIdx;
  logic                      lHit;
  logic [BREADTH-1:0]        eligible;
  logic [SLOT_W-1:0]         bestSlot;
  logic [1:0]                bestConf;
  logic [ADDR_W-1:0]         bestAddr;
  logic [BREADTH*ADDR_W-1:0] lookAddr;

  always_comb begin
    lIdx     = hashIdx(keyAddr);
    lHit     = tagVld[lIdx] && (tagArr[lIdx] == keyAddr);
    bestSlot = '0;
    bestConf = 2'd0;
    for (int s = 0; s < BREADTH; s++) begin
      eligible[s] = lHit && (confArr[lIdx][s] >= 2'd2);
      lookAddr[s*ADDR_W +: ADDR_W] = succArr[lIdx][s];
      if (eligible[s] && confArr[lIdx][s] > bestConf) begin
        bestConf = confArr[lIdx][s];
        bestSlot = SLOT_W'(s);
      end
    end
    chainOk  = |eligible;
    bestAddr = succArr[lIdx][bestSlot];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      prevAddr <= '0;
      keyAddr  <= '0;
      prevVld  <= 1'b0;
      pfValid  <= '0;
      pfAddr   <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        tagVld[e] <= 1'b0;
        tagArr[e] <= '0;
        for (int s = 0; s < BREADTH; s++) begin
          succArr[e][s] <= '0;
          confArr[e][s] <= 2'd0;
        end
      end
    end else begin
      if (strobe.capture) curAddr <= missAddr;
      if (strobe.train) begin
        if (prevVld) begin
          tagArr[tIdx] <= prevAddr;
          tagVld[tIdx] <= 1'b1;
          for (int s = 0; s < BREADTH; s++) begin
            succArr[tIdx][s] <= nextSucc[s];
            confArr[tIdx][s] <= nextConf[s];
          end
        end
        prevAddr <= curAddr;
        prevVld  <= 1'b1;
        keyAddr  <= curAddr;
      end
      if (strobe.advance) keyAddr <= bestAddr;
      if (strobe.look) begin
        pfValid <= eligible;
        pfAddr  <= lookAddr;
      end else begin
        pfValid <= '0;
      end
    end
  end

  AST_TAG_GATES: assert property (@(posedge clk) disable iff (!rstN)
    (|pfValid) |-> ($past(lHit) && $past(strobe.look))); // R7

  AST_TRAIN_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.train |-> $past(strobe.capture)); // R2

endmodule

// File: rtl/corr_prefetcher.sv
module corr_prefetcher
  import cp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 4,
  parameter int BREADTH = 2,
  parameter int DEPTH   = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      missValid,
  input  logic [ADDR_W-1:0]         missAddr,
  output logic [BREADTH-1:0]        pfValid,
  output logic [BREADTH*ADDR_W-1:0] pfAddr
);

  cp_strobe_t strobe;
  logic       chainOk;

  cp_control #(.DEPTH(DEPTH)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .missValid (missValid),
    .chainOk   (chainOk),
    .strobe    (strobe)
  );

  cp_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BREADTH(BREADTH)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .missAddr (missAddr),
    .chainOk  (chainOk),
    .pfValid  (pfValid),
    .pfAddr   (pfAddr)
  );

  AST_NO_PF_IN_RESET: assert property (@(posedge clk)
    !rstN |=> pfValid == '0); // R1

endmodule

// File: tb/sim_corr_prefetcher.sv
module sim_corr_prefetcher;

  localparam int AW = 16;
  localparam int BR = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missValid = 1'b0;
  logic [AW-1:0] missAddr = '0;
  logic [BR-1:0] pfValid;
  logic [BR*AW-1:0] pfAddr;

  int nTests = 0;
  int nFail  = 0;

  logic [AW-1:0] seen [32];
  int seenCyc [32];
  int nSeen;

  corr_prefetcher #(.ADDR_W(AW), .IDX_W(4), .BREADTH(BR), .DEPTH(2)) u0 (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .pfValid(pfValid), .pfAddr(pfAddr)
  );

  always #5ns clk = ~clk;

  initial begin
    #(10ns * 200000);
    nFail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nTests + 1, nFail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    missValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doMiss(input logic [AW-1:0] a);
    nSeen = 0;
    @(negedge clk);
    missValid = 1'b1;
    missAddr  = a;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      missValid = 1'b0;
      for (int s = 0; s < BR; s++) begin
        if (pfValid[s] && nSeen < 32) begin
          seen[nSeen]    = pfAddr[s*AW +: AW];
          seenCyc[nSeen] = k;
          nSeen++;
        end
      end
    end
  endtask

  function automatic bit has(input logic [AW-1:0] a);
    for (int i = 0; i < nSeen; i++) if (seen[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic testReset();
    doReset();
    chk(pfValid == '0, "R1 pfValid after reset", int'(pfValid), 0);
    doMiss(16'h0001);
    chk(nSeen == 0, "R1 first miss after reset", nSeen, 0);
  endtask

  task automatic testTrain();
    doReset();
    doMiss(16'h0001); doMiss(16'h0002);
    doMiss(16'h0001);
    chk(!has(16'h0002), "R2 single sighting not prefetched", nSeen, 0);
    doMiss(16'h0002);
    doMiss(16'h0001);
    chk(has(16'h0002), "R2 second sighting prefetched", nSeen, 1);
  endtask

  task automatic testChain();
    // A=1 B=2 C=3: A->B, B->C twice each
    doReset();
    doMiss(16'h0001); doMiss(16'h0002); doMiss(16'h0003);
    doMiss(16'h0001); doMiss(16'h0002); doMiss(16'h0003);
    doMiss(16'h0001);
    chk(nSeen == 2, "R8 chain stops at depth", nSeen, 2);
    chk(nSeen >= 1 && seen[0] == 16'h0002 && seenCyc[0] == 3,
        "R3 level one timing", int'(seen[0]), 16'h0002);
    chk(nSeen >= 2 && seen[1] == 16'h0003 && seenCyc[1] == 4,
        "R8 level two successor", int'(seen[1]), 16'h0003);
    chk(!has(16'h0001), "R3 no output beyond chain", nSeen, 2);
  endtask

  task automatic testWeakLink();
    // A B C A B A : B holds C and A at count 1
    doReset();
    doMiss(16'h0001); doMiss(16'h0002); doMiss(16'h0003);
    doMiss(16'h0001); doMiss(16'h0002); doMiss(16'h0001);
    chk(nSeen == 1 && has(16'h0002), "R9 chain stops at weak link", nSeen, 1);
  endtask

  task automatic testBreadth();
    // D=1 E=2 F=3: D->E x3 then D->F x2
    doReset();
    for (int i = 0; i < 3; i++) begin doMiss(16'h0001); doMiss(16'h0002); end
    doMiss(16'h0001); doMiss(16'h0003);
    doMiss(16'h0001); doMiss(16'h0003);
    doMiss(16'h0001);
    chk(has(16'h0002), "R4 first successor", nSeen, 3);
    chk(has(16'h0003), "R4 second successor", nSeen, 3);
    chk(has(16'h0001), "R8 chain via tie to lower slot", nSeen, 3);
  endtask

  task automatic testSaturate();
    // D->E x5 (saturates at 3), then D->F x3 pulls E down to 1
    doReset();
    for (int i = 0; i < 5; i++) begin doMiss(16'h0001); doMiss(16'h0002); end
    for (int i = 0; i < 3; i++) begin doMiss(16'h0001); doMiss(16'h0003); end
    doMiss(16'h0001);
    chk(has(16'h0003), "R5 repeated successor prefetched", nSeen, 2);
    chk(!has(16'h0002), "R5 saturated count decays", nSeen, 2);
  endtask

  task automatic testReplace();
    // D->E x3, D->F once, D->G twice: G evicts F (lowest count)
    doReset();
    for (int i = 0; i < 3; i++) begin doMiss(16'h0001); doMiss(16'h0002); end
    doMiss(16'h0001); doMiss(16'h0003);
    doMiss(16'h0001); doMiss(16'h0004);
    doMiss(16'h0001); doMiss(16'h0004);
    doMiss(16'h0001);
    chk(has(16'h0002) && has(16'h0004), "R6 strong slot kept, new grows", nSeen, 3);
    chk(!has(16'h0003), "R6 lowest count evicted", nSeen, 3);
  endtask

  task automatic testAlias();
    // 0x0010 hashes to index 1, same as 0x0001
    doReset();
    doMiss(16'h0001); doMiss(16'h0002);
    doMiss(16'h0001); doMiss(16'h0002);
    doMiss(16'h0010);
    chk(nSeen == 0, "R7 tag mismatch gives nothing", nSeen, 0);
  endtask

  initial begin
    testReset();
    testTrain();
    testChain();
    testWeakLink();
    testBreadth();
    testSaturate();
    testReplace();
    testAlias();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule